// File: doc/BRIEF.md
# Fractional Prescaler Baud Generator

This block produces the 16x oversampling enable that a UART transmitter and receiver use to time their serial bits. The system clock first passes through an optional fractional prescaler that divides by M + N/8. The prescaler output then feeds a 16-bit divisor counter, which is built from a low and a high byte register. Each time the divisor counter finishes a full count of prescaler pulses, the block asserts a single-cycle enable.

A host writes the two divisor bytes, the prescaler register and the prescaler-select bit through dedicated write strobes. The select bit only changes while the enhanced-mode flag is high. Without the prescaler, the serial bit rate is the clock divided by 16 times the divisor. With the prescaler, that rate is further divided by M + N/8, and the long and short prescaler periods are spread evenly over each group of eight.

Top module: `uart_baud_tick_gen`

## Requirements
- R1: The divisor is the low byte plus 256 times the high byte. With the prescaler bypassed, `tick16_o` pulses exactly once every divisor clock cycles.
- R2: A divisor of 0 behaves as a divisor of 1, so `tick16_o` stays high on every cycle when the prescaler is bypassed.
- R3: After reset, the prescaler register holds 0x20 and the select bit is 0. M sits in bits [7:3] and N in bits [2:0], so the reset value means M=4 and N=0. Both divisor bytes reset to 0, and `tick16_o` is low while reset is held.
- R4: With the select bit at 1, any 8 consecutive tick intervals together span exactly D*(8*M+N) clocks. Each single interval lies between D*M and D*(M+1) clocks, inclusive.
- R5: A write to the select bit takes effect only if `enh_mode_i` is 1 in the same cycle. Otherwise the write is ignored and the tick spacing does not change.
- R6: An M field of 0 behaves as M=1.
- R7: A new divisor value does not cut short the tick interval already in progress. The interval that ends at the next tick keeps the old length, and the interval after it uses the new divisor.
- R8: When the tick period is longer than one clock, `tick16_o` stays high for one clock cycle only.
- R9: With the select bit set to 1 and the prescaler register at its reset value, ticks occur every 4*D clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_lo_we_i | input | 1 | Write strobe, divisor low byte |
| div_lo_i | input | 8 | Divisor low byte data |
| div_hi_we_i | input | 1 | Write strobe, divisor high byte |
| div_hi_i | input | 8 | Divisor high byte data |
| pre_we_i | input | 1 | Write strobe, prescaler register (M in [7:3], N in [2:0]) |
| pre_i | input | 8 | Prescaler register data |
| pre_sel_we_i | input | 1 | Write strobe, prescaler select bit |
| pre_sel_i | input | 1 | Prescaler select data (0 divide by 1, 1 divide by M+N/8) |
| enh_mode_i | input | 1 | Enhanced-mode flag, qualifies select writes |
| tick16_o | output | 1 | Single-cycle 16x baud enable |

## Verification
Some properties are checked by assertions on every cycle:
- The select bit never changes unless a write arrived while enhanced mode was on.
- The fractional accumulator stays cleared while the prescaler is bypassed.
- The gap between prescaler pulses stays within the maximum period that M allows.
- The divisor count holds between prescaler pulses, and every tick follows a prescaler pulse.

Other behaviour can only be shown by the bench's scenarios, because it depends on timing across many intervals:
- the exact tick spacing for each divisor;
- the eight-interval span D*(8M+N) and the even spread of long periods;
- the handling of zero values for M and the divisor;
- a divisor change deferred until the next terminal count.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
   localparam int unsigned BYTE_W_DEF  = 8;
   localparam int unsigned FRAC_W_DEF  = 3;
   localparam logic [7:0]  PRE_RST_DEF = 8'h20;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned FRAC_W  = 3,
   parameter logic [BYTE_W-1:0] PRE_RST = 8'h20,
   localparam int unsigned DIV_W  = 2 * BYTE_W,
   localparam int unsigned M_W    = BYTE_W - FRAC_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lo_we_i,
   input  logic [BYTE_W-1:0] lo_i,
   input  logic              hi_we_i,
   input  logic [BYTE_W-1:0] hi_i,
   input  logic              pre_we_i,
   input  logic [BYTE_W-1:0] pre_i,
   input  logic              sel_we_i,
   input  logic              sel_i,
   input  logic              enh_i,
   output logic [DIV_W-1:0]  div_eff_o,
   output logic [M_W-1:0]    m_eff_o,
   output logic [FRAC_W-1:0] n_o,
   output logic              sel_o
);
   logic [BYTE_W-1:0] lo_q, hi_q, pre_q;
   logic              sel_q;
   logic [DIV_W-1:0]  div_raw;
   logic [M_W-1:0]    m_raw;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lo_q  <= '0;
         hi_q  <= '0;
         pre_q <= PRE_RST;
         sel_q <= 1'b0;
      end else begin
         if (lo_we_i)  lo_q  <= lo_i;
         if (hi_we_i)  hi_q  <= hi_i;
         if (pre_we_i) pre_q <= pre_i;
         if (sel_we_i && enh_i) sel_q <= sel_i;
      end
   end

   always_comb begin
      div_raw   = {hi_q, lo_q};
      div_eff_o = (div_raw == '0) ? DIV_W'(1) : div_raw;
      m_raw     = pre_q[BYTE_W-1:FRAC_W];
      m_eff_o   = (m_raw == '0) ? M_W'(1) : m_raw;
      n_o       = pre_q[FRAC_W-1:0];
      sel_o     = sel_q;
   end

   // R5
   sel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q != $past(sel_q)) |-> $past(sel_we_i && enh_i));
endmodule

// File: rtl/baud_frac_prescaler.sv
module baud_frac_prescaler #(
   parameter int unsigned M_W     = 5,
   parameter int unsigned FRAC_W  = 3,
   parameter bit          FRAC_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic [M_W-1:0]    m_i,
   input  logic [FRAC_W-1:0] n_i,
   output logic              pulse_o
);
   if (FRAC_EN) begin : g_frac
      logic [M_W-1:0]    pcnt_q;
      logic [FRAC_W-1:0] acc_q;
      logic [FRAC_W:0]   acc_sum;
      logic              period_end;
      logic [M_W+1:0]    gap_q;

      always_comb begin
         acc_sum    = {1'b0, acc_q} + {1'b0, n_i};
         period_end = (pcnt_q == '0);
         pulse_o    = !sel_i || period_end;
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni || !sel_i) begin
            pcnt_q <= '0;
            acc_q  <= '0;
         end else if (period_end) begin
            acc_q  <= acc_sum[FRAC_W-1:0];
            pcnt_q <= (m_i - M_W'(1)) + M_W'(acc_sum[FRAC_W]);
         end else begin
            pcnt_q <= pcnt_q - M_W'(1);
         end
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni || pulse_o) gap_q <= '0;
         else                    gap_q <= gap_q + 1'b1;
      end

      // R4
      prescaler_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         gap_q < (M_W+2)'(2 ** M_W));

      // R1
      bypass_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !sel_i |=> (acc_q == '0) || sel_i);
   end else begin : g_bypass
      assign pulse_o = 1'b1;
   end
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pulse_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             term;

   assign term = (cnt_q == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= pulse_i && term;
         if (pulse_i) begin
            if (term) cnt_q <= div_i - DIV_W'(1);
            else      cnt_q <= cnt_q - DIV_W'(1);
         end
      end
   end

   // R7
   hold_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pulse_i |=> $stable(cnt_q));

   // R8
   tick_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> $past(pulse_i));
endmodule

// File: rtl/uart_baud_tick_gen.sv
module uart_baud_tick_gen
   import uart_baud_pkg::*;
#(
   parameter int unsigned BYTE_W  = BYTE_W_DEF,
   parameter int unsigned FRAC_W  = FRAC_W_DEF,
   parameter bit          FRAC_EN = 1'b1,
   parameter logic [7:0]  PRE_RST = PRE_RST_DEF
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        div_lo_we_i,
   input  logic [7:0]  div_lo_i,
   input  logic        div_hi_we_i,
   input  logic [7:0]  div_hi_i,
   input  logic        pre_we_i,
   input  logic [7:0]  pre_i,
   input  logic        pre_sel_we_i,
   input  logic        pre_sel_i,
   input  logic        enh_mode_i,
   output logic        tick16_o
);
   localparam int unsigned DIV_W = 2 * BYTE_W;
   localparam int unsigned M_W   = BYTE_W - FRAC_W;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("BYTE_W must be 8 to match the port widths");
   end
   if (FRAC_W < 1 || FRAC_W >= BYTE_W) begin : g_bad_frac
      $error("FRAC_W must lie between 1 and BYTE_W-1");
   end

   logic [DIV_W-1:0]  div_eff;
   logic [M_W-1:0]    m_eff;
   logic [FRAC_W-1:0] n_val;
   logic              sel;
   logic              pre_pulse;

   baud_cfg_regs #(
      .BYTE_W (BYTE_W),
      .FRAC_W (FRAC_W),
      .PRE_RST(PRE_RST)
   ) i_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lo_we_i  (div_lo_we_i),
      .lo_i     (div_lo_i),
      .hi_we_i  (div_hi_we_i),
      .hi_i     (div_hi_i),
      .pre_we_i (pre_we_i),
      .pre_i    (pre_i),
      .sel_we_i (pre_sel_we_i),
      .sel_i    (pre_sel_i),
      .enh_i    (enh_mode_i),
      .div_eff_o(div_eff),
      .m_eff_o  (m_eff),
      .n_o      (n_val),
      .sel_o    (sel)
   );

   baud_frac_prescaler #(
      .M_W    (M_W),
      .FRAC_W (FRAC_W),
      .FRAC_EN(FRAC_EN)
   ) i_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel),
      .m_i    (m_eff),
      .n_i    (n_val),
      .pulse_o(pre_pulse)
   );

   baud_div_counter #(
      .DIV_W(DIV_W)
   ) i_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pulse_i(pre_pulse),
      .div_i  (div_eff),
      .tick_o (tick16_o)
   );
endmodule

// File: tb/test_uart_baud_tick_gen.sv
module test_uart_baud_tick_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lo_we = 0, hi_we = 0, pre_we = 0, sel_we = 0, sel_d = 0, enh = 0;
   logic [7:0] lo_d = 0, hi_d = 0, pre_d = 0;
   logic       tick;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int n = 0;
   int ts[0:63];
   bit timed_out = 0;

   always #5 clk = ~clk;

   uart_baud_tick_gen i_uart_baud_tick_gen (
      .clk_i(clk), .rst_ni(rst_n),
      .div_lo_we_i(lo_we), .div_lo_i(lo_d),
      .div_hi_we_i(hi_we), .div_hi_i(hi_d),
      .pre_we_i(pre_we), .pre_i(pre_d),
      .pre_sel_we_i(sel_we), .pre_sel_i(sel_d),
      .enh_mode_i(enh), .tick16_o(tick)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (cyc > 150000) timed_out = 1;
      if (tick && n < 64) begin
         ts[n] = cyc;
         n = n + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_ticks(input int k);
      while (n < k && !timed_out) @(negedge clk);
   endtask

   task automatic wr(input int which, input logic [7:0] v);
      @(negedge clk);
      case (which)
         0: begin lo_we = 1; lo_d = v; end
         1: begin hi_we = 1; hi_d = v; end
         2: begin pre_we = 1; pre_d = v; end
         default: begin sel_we = 1; sel_d = v[0]; end
      endcase
      @(negedge clk);
      lo_we = 0; hi_we = 0; pre_we = 0; sel_we = 0;
   endtask

   function automatic int eff_div(input int d);
      return (d == 0) ? 1 : d;
   endfunction

   function automatic int eff_m(input int p);
      return ((p >> 3) == 0) ? 1 : (p >> 3);
   endfunction

   task automatic measure(input string req, input int d, input bit fr, input int p);
      int de, m, nn;
      de = eff_div(d);
      m  = eff_m(p);
      nn = p & 7;
      @(negedge clk);
      n = 0;
      wait_ticks(12);
      if (timed_out) return;
      for (int i = 2; i < 10; i++) begin
         if (fr) check_rng(req, ts[i+1] - ts[i], de * m, de * (m + 1));
         else    check(req, ts[i+1] - ts[i], de);
      end
      check(req, ts[10] - ts[2], fr ? de * (8 * m + nn) : 8 * de);
   endtask

   task automatic set_div(input int d);
      wr(0, d[7:0]);
      wr(1, d[15:8]);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check("R3 tick low in reset", int'(tick), 0);
      rst_n = 1;
      // R2 R3: reset divisor 0 acts as 1, prescaler bypassed
      measure("R2", 0, 0, 32'h20);
      // R1: byte composition, bypass
      set_div(7);
      measure("R1 low byte", 7, 0, 0);
      set_div(300);
      measure("R1 high byte", 300, 0, 0);
      // R5: select write ignored without enhanced mode
      set_div(5);
      enh = 0;
      wr(3, 8'h1);
      measure("R5 ignored", 5, 0, 0);
      // R9: default prescaler register 0x20 gives divide by 4
      enh = 1;
      wr(3, 8'h1);
      measure("R9", 5, 1, 32'h20);
      // R4: fractional spread
      wr(2, 8'h2B);
      measure("R4 M5 N3", 5, 1, 32'h2B);
      // R6: M field zero acts as one
      set_div(2);
      wr(2, 8'h00);
      measure("R6 M0", 2, 1, 32'h00);
      wr(2, 8'h05);
      measure("R6 M0 N5", 2, 1, 32'h05);
      // R5: clear select with enhanced mode on
      wr(3, 8'h0);
      measure("R5 clear", 2, 0, 0);
      // R8: single-cycle tick
      set_div(3);
      @(negedge clk);
      begin
         int highs, pairs;
         bit prev;
         highs = 0; pairs = 0; prev = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tick) highs++;
            if (tick && prev) pairs++;
            prev = tick;
         end
         check("R8 count", highs, 10);
         check("R8 width", pairs, 0);
      end
      // R7: divisor change deferred to next terminal count
      set_div(10);
      measure("R7 setup", 10, 0, 0);
      n = 0;
      wait_ticks(1);
      wr(0, 8'd3);
      wait_ticks(3);
      check("R7 old interval", ts[1] - ts[0], 10);
      check("R7 new interval", ts[2] - ts[1], 3);
      // R4: constrained random mix
      for (int t = 0; t < 6; t++) begin
         int d, p;
         bit fr;
         d  = int'($urandom_range(0, 20));
         p  = int'($urandom_range(0, 127));
         fr = 1'($urandom_range(0, 1));
         set_div(d);
         wr(2, p[7:0]);
         wr(3, {7'b0, fr});
         measure(fr ? "R4 random" : "R1 random", d, fr, p);
      end
      if (timed_out) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule